// File: doc/BRIEF.md
# Indexed Register and Memory Access Window

This block is a slave on a 32-bit register bus with byte enables. It holds a 32-bit pointer register and exposes a data window. An access to the data window is redirected to one of two targets. If the pointer's top bit is set, the access goes to a video memory port. If the top bit is clear, the access goes to an internal register space. Software loads the pointer once and then moves data through the window with 1-, 2- or 4-byte accesses.

Memory accesses are bounds-checked against a memory size parameter and use a request/ready handshake. The bus stalls while a memory request is in flight. Register accesses are re-addressed at pointer plus the byte offset of the access within the window. They are read-modify-written as whole words, and the block extracts or deposits only the addressed byte field. Data is little-endian throughout. Bus data sits on its natural byte lanes, and data on the memory and register sides is right-justified.

Top module: `iaw_top`

## Requirements
- R1: After reset the pointer register (bus word 0) reads 0 and `bus_ready` is high. Writes to word 0 update only the byte lanes whose enable bit is set, and a read of word 0 returns the whole register.
- R2: With pointer bit 31 = 1, a window access (bus word 1) issues one memory request at byte address pointer[30:0], with no lane offset added. `mem_size` is 0, 1 or 2 for 1, 2 or 4 bytes. Write data is taken from the enabled lanes and right-justified. Read data comes back placed on the enabled lanes.
- R3: A memory access is performed only when pointer[30:0] + size ≤ MEM_BYTES. Otherwise no memory request is made, a write is dropped and a read returns 0.
- R4: From acceptance of an in-range memory access until the edge where `mem_ready` is seen, `bus_ready` is low and `mem_req`, `mem_addr`, `mem_we` and `mem_size` stay constant.
- R5: With pointer bit 31 = 0, a window access targets register byte address A = pointer + o, where o is the lowest enabled lane. `reg_addr` is A[REG_AW+1:2].
- R6: A forwarded register read of n bytes returns register bits [8r+8n-1:8r] (r = A[1:0]), placed on bus lanes starting at lane o.
- R7: A forwarded register write replaces only bits [8r+8n-1:8r] of the word and keeps the others. A 4-byte write at r = 0 replaces the whole word.
- R8: A forwarded register access is blocked when its word is 0 or 1 (the block's own words), when r + n > 4, or when the word is outside the 2^REG_AW register words. A blocked access reads 0 and makes no register write.
- R9: The legal window byte enables are 0001, 0010, 0100, 1000, 0011, 0110, 1100 and 1111. Any other pattern, and any access to bus words 2 and 3, has no effect and reads 0.
- R10: Each accepted read produces exactly one `bus_rvalid` pulse with its data. A register or pointer read gets its pulse in the cycle after acceptance. A memory read gets its pulse in the cycle after the `mem_ready` edge. Writes never produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | BUS_AW | Word address (0 pointer, 1 window) |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data on byte lanes |
| bus_ready | output | 1 | Access accepted when high with bus_req |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_rdata | output | 32 | Read data on byte lanes |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | Memory write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_size | output | 2 | 0/1/2 = 1/2/4 bytes |
| mem_wdata | output | 32 | Right-justified little-endian write data |
| mem_ready | input | 1 | Memory completion |
| mem_rdata | input | 32 | Right-justified read data, valid with mem_ready |
| reg_addr | output | REG_AW | Register word address |
| reg_rdata | input | 32 | Combinational read of reg_addr |
| reg_we | output | 1 | Full-word register write strobe |
| reg_wdata | output | 32 | Merged register word |

## Verification
The bench probes the memory bound at the exact limit, at one byte past it, and at the last byte of memory. An off-by-one comparator would either drop a legal last access or let a read run past the end. It forwards register accesses whose lane offset carries the address into the next byte or word. A design that ignored the lane offset, or that shifted by the bus lane instead of the register lane, would return the wrong byte. It also forwards partial writes that must preserve neighbouring bytes, and accesses that cross a word or point back at the window; a missing guard would corrupt or recurse. Finally it counts read-valid pulses against issued reads, to catch stray responses on writes and missing responses after memory stalls.

// File: rtl/iaw_pkg.sv
package iaw_pkg;

    typedef enum logic { ST_IDLE = 1'b0, ST_MEM = 1'b1 } iaw_state_e;

    // access size code, also driven on mem_size
    typedef enum logic [1:0] { SZ_1 = 2'd0, SZ_2 = 2'd1, SZ_4 = 2'd2 } iaw_size_e;

    localparam int WORD_PTR    = 0;
    localparam int WORD_WINDOW = 1;

    function automatic logic [31:0] size_mask(iaw_size_e sz);
        case (sz)
            SZ_1:    return 32'h0000_00FF;
            SZ_2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [2:0] size_bytes(iaw_size_e sz);
        case (sz)
            SZ_1:    return 3'd1;
            SZ_2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/iaw_be_decode.sv
module iaw_be_decode
    import iaw_pkg::*;
(
    input  logic [3:0] be,
    output logic       legal,
    output logic [1:0] lane,
    output iaw_size_e  size
);
    always_comb begin
        legal = 1'b1;
        lane  = 2'd0;
        size  = SZ_1;
        case (be)
            4'b0001: begin lane = 2'd0; size = SZ_1; end
            4'b0010: begin lane = 2'd1; size = SZ_1; end
            4'b0100: begin lane = 2'd2; size = SZ_1; end
            4'b1000: begin lane = 2'd3; size = SZ_1; end
            4'b0011: begin lane = 2'd0; size = SZ_2; end
            4'b0110: begin lane = 2'd1; size = SZ_2; end
            4'b1100: begin lane = 2'd2; size = SZ_2; end
            4'b1111: begin lane = 2'd0; size = SZ_4; end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/iaw_mem_check.sv
module iaw_mem_check
    import iaw_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int MEM_AW   = $clog2(MEM_BYTES)
) (
    input  logic [30:0]       ptr,
    input  iaw_size_e         size,
    output logic              in_range,
    output logic [MEM_AW-1:0] addr
);
    logic [31:0] end_addr;

    always_comb begin
        end_addr = {1'b0, ptr} + 32'(size_bytes(size));
        in_range = end_addr <= 32'(MEM_BYTES);
        addr     = ptr[MEM_AW-1:0];
    end
endmodule

// File: rtl/iaw_reg_merge.sv
module iaw_reg_merge
    import iaw_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic [30:0]       ptr,
    input  logic [1:0]        lane,
    input  iaw_size_e         size,
    input  logic [31:0]       wjust,
    input  logic [31:0]       reg_rdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic              blocked,
    output logic [31:0]       rd_just,
    output logic [31:0]       wr_word
);
    logic [31:0] byte_addr;
    logic [29:0] word;
    logic [1:0]  rlane;
    logic [31:0] fmask;
    logic        crosses;
    logic        own_word;
    logic        out_of_range;

    always_comb begin
        byte_addr    = {1'b0, ptr} + {30'd0, lane};
        word         = byte_addr[31:2];
        rlane        = byte_addr[1:0];
        crosses      = ({1'b0, rlane} + size_bytes(size)) > 3'd4;
        own_word     = word <= 30'(WORD_WINDOW);
        out_of_range = (word >> REG_AW) != 30'd0;
        blocked      = crosses | own_word | out_of_range;
        reg_addr     = word[REG_AW-1:0];
        fmask        = size_mask(size) << {rlane, 3'b000};
        rd_just      = (reg_rdata >> {rlane, 3'b000}) & size_mask(size);
        wr_word      = (reg_rdata & ~fmask) | ((wjust << {rlane, 3'b000}) & fmask);
    end
endmodule

// File: rtl/iaw_top.sv
module iaw_top
    import iaw_pkg::*;
#(
    parameter int BUS_AW    = 2,
    parameter int REG_AW    = 4,
    parameter int MEM_BYTES = 1024,
    localparam int MEM_AW   = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_word,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_rdata,
    output logic              reg_we,
    output logic [31:0]       reg_wdata
);
    typedef struct packed {
        iaw_state_e        st;
        logic [31:0]       ptr;
        logic              rvalid;
        logic [31:0]       rdata;
        logic [MEM_AW-1:0] maddr;
        iaw_size_e         msize;
        logic              mwe;
        logic [31:0]       mwdata;
        logic [1:0]        mlane;
    } iaw_regs_t;

    iaw_regs_t q, d;

    logic        be_legal;
    logic [1:0]  lane;
    iaw_size_e   size;
    logic        mem_ok;
    logic [MEM_AW-1:0] m_addr;
    logic        reg_blocked;
    logic [31:0] rd_just;
    logic [31:0] wr_word;
    logic [31:0] wjust;
    logic        accept;
    logic        is_ptr;
    logic        win_ok;
    logic        to_mem;
    logic        to_reg;

    iaw_be_decode u_be (
        .be    (bus_be),
        .legal (be_legal),
        .lane  (lane),
        .size  (size)
    );

    iaw_mem_check #(.MEM_BYTES(MEM_BYTES)) u_mchk (
        .ptr      (q.ptr[30:0]),
        .size     (size),
        .in_range (mem_ok),
        .addr     (m_addr)
    );

    iaw_reg_merge #(.REG_AW(REG_AW)) u_merge (
        .ptr       (q.ptr[30:0]),
        .lane      (lane),
        .size      (size),
        .wjust     (wjust),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .blocked   (reg_blocked),
        .rd_just   (rd_just),
        .wr_word   (wr_word)
    );

    assign bus_ready = (q.st == ST_IDLE);
    assign accept    = bus_req & bus_ready;
    assign is_ptr    = bus_word == BUS_AW'(WORD_PTR);
    assign win_ok    = (bus_word == BUS_AW'(WORD_WINDOW)) & be_legal;
    assign wjust     = (bus_wdata >> {lane, 3'b000}) & size_mask(size);
    assign to_mem    = win_ok & q.ptr[31] & mem_ok;
    assign to_reg    = win_ok & ~q.ptr[31] & ~reg_blocked;

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        if (q.st == ST_IDLE) begin
            if (accept) begin
                if (is_ptr) begin
                    if (bus_we) begin
                        for (int b = 0; b < 4; b++) begin
                            if (bus_be[b]) d.ptr[8*b +: 8] = bus_wdata[8*b +: 8];
                        end
                    end else begin
                        d.rvalid = 1'b1;
                        d.rdata  = q.ptr;
                    end
                end else if (to_mem) begin
                    d.st     = ST_MEM;
                    d.maddr  = m_addr;
                    d.msize  = size;
                    d.mwe    = bus_we;
                    d.mwdata = wjust;
                    d.mlane  = lane;
                end else if (!bus_we) begin
                    d.rvalid = 1'b1;
                    d.rdata  = to_reg ? (rd_just << {lane, 3'b000}) : 32'd0;
                end
            end
        end else begin
            if (mem_ready) begin
                d.st     = ST_IDLE;
                d.rvalid = ~q.mwe;
                d.rdata  = (mem_rdata & size_mask(q.msize)) << {q.mlane, 3'b000};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ptr: '0, rvalid: 1'b0, rdata: '0, maddr: '0,
                   msize: SZ_1, mwe: 1'b0, mwdata: '0, mlane: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_rvalid = q.rvalid;
    assign bus_rdata  = q.rdata;
    assign mem_req    = (q.st == ST_MEM);
    assign mem_we     = q.mwe;
    assign mem_addr   = q.maddr;
    assign mem_size   = q.msize;
    assign mem_wdata  = q.mwdata;
    assign reg_we     = accept & bus_we & to_reg;
    assign reg_wdata  = wr_word;

    // R4: request held steady while waiting on memory
    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

    // R4: bus stalled while memory outstanding
    assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !bus_ready);

    // R3: no request ever leaves the memory range
    assert_mem_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({{(32-MEM_AW){1'b0}}, mem_addr} + 32'(size_bytes(iaw_size_e'(mem_size)))) <= 32'(MEM_BYTES));

    // R8: forwarded writes never land on the block's own words
    assert_reg_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_addr > REG_AW'(WORD_WINDOW));

    // R10: a write never yields a read response
    assert_no_rvalid_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ready && bus_we |=> !bus_rvalid);

    // R7: register write strobe only for an accepted bus write
    assert_reg_we_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> bus_req && bus_ready && bus_we);
endmodule

// File: tb/tb_iaw_top.sv
module tb_iaw_top;
    localparam int BUS_AW    = 2;
    localparam int REG_AW    = 4;
    localparam int MEM_BYTES = 1024;
    localparam int MEM_AW    = $clog2(MEM_BYTES);
    localparam int LAT       = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [BUS_AW-1:0] bus_word = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ready, bus_rvalid;
    logic [31:0]       bus_rdata;
    logic              mem_req, mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [1:0]        mem_size;
    logic [31:0]       mem_wdata;
    logic              mem_ready = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic [REG_AW-1:0] reg_addr;
    logic [31:0]       reg_rdata;
    logic              reg_we;
    logic [31:0]       reg_wdata;

    iaw_top #(.BUS_AW(BUS_AW), .REG_AW(REG_AW), .MEM_BYTES(MEM_BYTES)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .reg_we(reg_we), .reg_wdata(reg_wdata)
    );

    logic [7:0]  mem_m [0:MEM_BYTES-1];
    logic [31:0] regs_m [0:(1<<REG_AW)-1];
    int lat_cnt = 0;
    int mem_hits = 0;
    int reg_writes = 0;
    int rv_cnt = 0;
    int reads_issued = 0;
    int checks = 0;
    int fails = 0;

    assign reg_rdata = regs_m[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            regs_m[reg_addr] <= reg_wdata;
            reg_writes <= reg_writes + 1;
        end
        if (bus_rvalid) rv_cnt <= rv_cnt + 1;
    end

    always @(posedge clk) begin
        if (mem_ready) begin
            if (mem_we) begin
                for (int k = 0; k < (1 << mem_size); k++)
                    mem_m[int'(mem_addr) + k] = mem_wdata[8*k +: 8];
            end
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
            mem_hits  <= mem_hits + 1;
        end else if (mem_req) begin
            if (lat_cnt == LAT - 1) begin
                logic [31:0] v;
                v = '0;
                for (int k = 0; k < (1 << mem_size); k++)
                    v[8*k +: 8] = mem_m[int'(mem_addr) + k];
                mem_rdata <= v;
                mem_ready <= 1'b1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int word, input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_word = BUS_AW'(word);
        bus_be = be; bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        for (int t = 0; t < 50 && !bus_ready; t++) @(negedge clk);
    endtask

    task automatic bus_rd(input int word, input logic [3:0] be,
                          output logic [31:0] data, output int stall);
        stall = 0;
        data  = 'x;
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_word = BUS_AW'(word); bus_be = be;
        reads_issued++;
        @(posedge clk);
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            bus_req = 1'b0;
            if (bus_rvalid) begin
                data = bus_rdata;
                break;
            end
            if (!bus_ready) stall++;
        end
    endtask

    task automatic set_ptr(input logic [31:0] p);
        bus_wr(0, 4'b1111, p);
    endtask

    task automatic t_reset;
        logic [31:0] v; int s;
        check("R1 ready after reset", {31'd0, bus_ready}, 32'd1);
        bus_rd(0, 4'b1111, v, s);
        check("R1 pointer reset value", v, 32'd0);
    endtask

    task automatic t_pointer;
        logic [31:0] v; int s;
        set_ptr(32'hAABB_CCDD);
        bus_wr(0, 4'b0010, 32'h0000_1100);
        bus_rd(0, 4'b1111, v, s);
        check("R1 pointer byte-lane write", v, 32'hAABB_11DD);
    endtask

    task automatic t_mem_byte;
        set_ptr(32'h8000_0010);
        bus_wr(1, 4'b0100, 32'h00EE_0000);
        check("R2 memory byte at pointer", {24'd0, mem_m[16]}, 32'h0000_00EE);
        check("R2 neighbour byte untouched", {24'd0, mem_m[17]}, 32'd0);
    endtask

    task automatic t_mem_word;
        logic [31:0] v; int s;
        set_ptr(32'h8000_0020);
        bus_wr(1, 4'b1111, 32'h1122_3344);
        check("R2 memory word low byte", {24'd0, mem_m[32]}, 32'h44);
        check("R2 memory word high byte", {24'd0, mem_m[35]}, 32'h11);
        bus_rd(1, 4'b1100, v, s);
        check("R2 memory halfword read on upper lanes", v, 32'h3344_0000);
        check("R4 bus stalled during memory read", {31'd0, s > 0}, 32'd1);
        bus_rd(1, 4'b1111, v, s);
        check("R2 memory word read", v, 32'h1122_3344);
    endtask

    task automatic t_bounds;
        logic [31:0] v; int s; int h;
        set_ptr(32'h8000_0000 | (MEM_BYTES - 4));
        bus_wr(1, 4'b1111, 32'hDEAD_BEEF);
        check("R3 word at exact limit written", {24'd0, mem_m[MEM_BYTES-1]}, 32'hDE);
        set_ptr(32'h8000_0000 | (MEM_BYTES - 3));
        h = mem_hits;
        bus_wr(1, 4'b1111, 32'h0102_0304);
        check("R3 write past limit dropped", {24'd0, mem_m[MEM_BYTES-3]}, 32'hBE);
        bus_rd(1, 4'b1111, v, s);
        check("R3 read past limit returns zero", v, 32'd0);
        check("R3 no memory request past limit", 32'(mem_hits - h), 32'd0);
        set_ptr(32'h8000_0000 | (MEM_BYTES - 1));
        bus_wr(1, 4'b0001, 32'h0000_0077);
        check("R3 last byte of memory written", {24'd0, mem_m[MEM_BYTES-1]}, 32'h77);
    endtask

    task automatic t_reg_forward;
        logic [31:0] v; int s;
        set_ptr(32'h0000_0008);
        bus_wr(1, 4'b1111, 32'hCAFE_F00D);
        check("R7 full register write", regs_m[2], 32'hCAFE_F00D);
        set_ptr(32'h0000_0009);
        bus_rd(1, 4'b0001, v, s);
        check("R6 byte read register lane 1 to bus lane 0", v, 32'h0000_00F0);
        bus_rd(1, 4'b0011, v, s);
        check("R6 halfword read at register lane 1", v, 32'h0000_FEF0);
        set_ptr(32'h0000_0008);
        bus_rd(1, 4'b0010, v, s);
        check("R5 lane offset added to pointer", v, 32'h0000_F000);
    endtask

    task automatic t_reg_partial;
        set_ptr(32'h0000_000A);
        bus_wr(1, 4'b0001, 32'h0000_005A);
        check("R7 byte write keeps other bits", regs_m[2], 32'hCA5A_F00D);
        set_ptr(32'h0000_000C);
        bus_wr(1, 4'b1111, 32'hFFFF_FFFF);
        bus_wr(1, 4'b1100, 32'h1234_0000);
        check("R5 halfword write at pointer plus lane", regs_m[3], 32'h1234_FFFF);
    endtask

    task automatic t_blocked;
        logic [31:0] v; int s; int w;
        w = reg_writes;
        set_ptr(32'h0000_0004);
        bus_wr(1, 4'b1111, 32'h1111_1111);
        bus_rd(1, 4'b1111, v, s);
        check("R8 window target reads zero", v, 32'd0);
        set_ptr(32'h0000_000B);
        bus_wr(1, 4'b0011, 32'h0000_9999);
        check("R8 crossing write keeps register", regs_m[2], 32'hCA5A_F00D);
        bus_rd(1, 4'b0011, v, s);
        check("R8 crossing read zero", v, 32'd0);
        set_ptr(32'h0000_0040);
        bus_wr(1, 4'b1111, 32'h2222_2222);
        check("R8 no register write on blocked accesses", 32'(reg_writes - w), 32'd0);
    endtask

    task automatic t_illegal;
        logic [31:0] v; int s; int h;
        set_ptr(32'h8000_0030);
        h = mem_hits;
        bus_wr(1, 4'b0101, 32'h3333_3333);
        bus_rd(1, 4'b1010, v, s);
        check("R9 illegal enables read zero", v, 32'd0);
        check("R9 illegal enables make no memory access", 32'(mem_hits - h), 32'd0);
        bus_wr(2, 4'b1111, 32'h4444_4444);
        bus_rd(3, 4'b1111, v, s);
        check("R9 unused bus word reads zero", v, 32'd0);
        bus_rd(0, 4'b1111, v, s);
        check("R9 unused word write leaves pointer", v, 32'h8000_0030);
    endtask

    task automatic t_rvalid;
        repeat (3) @(negedge clk);
        check("R10 one read pulse per read", 32'(rv_cnt), 32'(reads_issued));
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) mem_m[i] = 8'd0;
        for (int i = 0; i < (1 << REG_AW); i++) regs_m[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_pointer;
        t_mem_byte;
        t_mem_word;
        t_bounds;
        t_reg_forward;
        t_reg_partial;
        t_blocked;
        t_illegal;
        t_rvalid;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule